// File: doc/BRIEF.md
# Dual-Bank Enable Router

This block sits between a shared external memory bus and two memory banks, a volatile SRAM bank and a nonvolatile flash bank, that share one address, one data path, one write strobe and one output strobe. Two active-low bank enables pick the bank. From these the block derives a read strobe and a write strobe for each bank, the address each bank sees, a registered drive enable for the tri-state data pins together with the data to place on them, and a registered standby flag.

The flash enable has priority. When both enables are low, the SRAM enable is ignored and the cycle goes to flash. Flash write strobes are suppressed while the flash bank reports an internal operation in progress. The SRAM path ignores that busy state, so code can run from SRAM while flash is busy. A build-time mode merges the SRAM enable and the output enable onto one shared pin. While flash is selected, the pin works as the output enable. Otherwise it works as the SRAM enable. The memory arrays are outside the block.

Top module: `combo_bank_router`

## Requirements
- R1: When the flash enable is low, the SRAM strobes stay low whatever the SRAM enable is, and flash read/write strobes follow the flash rules.
- R2: When both effective enables are high, no strobe is active and, one clock later, `dq_oe_o` is 0 and `standby_o` is 1.
- R3: A bank read strobe is high when that bank is active, the output enable is low and the write enable is high. One clock later, `dq_oe_o` is 1 and `dq_o` carries that bank's read data.
- R4: An SRAM write strobe is high when the SRAM bank is active and the write enable is low, whatever the output enable level.
- R5: The flash write strobe is high only when the flash enable is low, the write enable is low, the output enable is high and `flash_busy_i` is 0.
- R6: `sram_addr_o` carries the low log2(SRAM_BYTES) bits of `addr_i` (17 bits by default). `flash_addr_o` carries all of `addr_i`.
- R7: `flash_busy_i` has no effect on the SRAM strobes, on the SRAM read data or on the drive enable of an SRAM read.
- R8: With SHARED_PIN=1, `out_en_ni` acts as the output enable while flash is selected and as the SRAM enable otherwise, and `sram_sel_ni` is ignored. A high pin gives `dq_oe_o`=0 one clock later.
- R9: `dq_oe_o`, `dq_o` and `standby_o` are registered. Under reset they are 0, 0 and 1.
- R10: Whenever `dq_oe_o` is 0, `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flash_sel_ni | input | 1 | Flash bank enable, active low, has priority |
| sram_sel_ni | input | 1 | SRAM bank enable, active low (ignored in shared-pin mode) |
| out_en_ni | input | 1 | Output enable, active low; the shared pin in shared-pin mode |
| wr_en_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Shared address |
| flash_busy_i | input | 1 | Flash internal operation in progress |
| sram_rdata_i | input | DATA_W | Read data from the SRAM bank |
| flash_rdata_i | input | DATA_W | Read data from the flash bank |
| sram_addr_o | output | log2(SRAM_BYTES) | Address to the SRAM bank |
| flash_addr_o | output | ADDR_W | Address to the flash bank |
| sram_rd_o | output | 1 | SRAM read strobe |
| sram_wr_o | output | 1 | SRAM write strobe |
| flash_rd_o | output | 1 | Flash read strobe |
| flash_wr_o | output | 1 | Flash write strobe |
| dq_oe_o | output | 1 | Registered drive enable for the data pins |
| dq_o | output | DATA_W | Registered data for the data pins |
| standby_o | output | 1 | Registered standby flag |

## Verification
Strobes and bank addresses depend combinationally on the pins, so they are due in the same cycle as the stimulus. The bench samples them one time unit after it drives the inputs, well before the next rising edge. `dq_oe_o`, `dq_o` and `standby_o` pass through one register, so they are due after the first rising edge that follows the stimulus. The bench holds the inputs stable across that edge and samples these outputs one time unit after it. A behavioural model computes both sets of expected values, for a separate-pin instance and for a shared-pin instance, over directed corner cases and a long random sweep.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef struct packed {
    logic flash_on;
    logic sram_on;
    logic oe_n;
    logic we_n;
  } sel_t;

  typedef struct packed {
    logic f_rd;
    logic f_wr;
    logic s_rd;
    logic s_wr;
  } strobe_t;
endpackage

// File: rtl/cbr_select.sv
module cbr_select
  import cbr_pkg::*;
#(
  parameter bit SHARED_PIN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flash_sel_ni,
  input  logic sram_sel_ni,
  input  logic out_en_ni,
  input  logic wr_en_ni,
  output sel_t sel_o,
  output logic idle_o
);
  logic s_en_n;

  generate
    if (SHARED_PIN) begin : g_shared
      // one pin: SRAM enable when flash is off, output enable when flash is on
      assign s_en_n = out_en_ni;
    end else begin : g_split
      assign s_en_n = sram_sel_ni;
    end
  endgenerate

  always_comb begin
    sel_o.flash_on = ~flash_sel_ni;
    sel_o.sram_on  = ~s_en_n & flash_sel_ni;
    sel_o.oe_n     = out_en_ni;
    sel_o.we_n     = wr_en_ni;
    idle_o         = flash_sel_ni & s_en_n;
  end

  p_flash_wins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_sel_ni |-> !sel_o.sram_on);

  p_idle_none_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !(sel_o.flash_on || sel_o.sram_on));
endmodule

// File: rtl/cbr_strobe.sv
module cbr_strobe
  import cbr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sel_t    sel_i,
  input  logic    busy_i,
  output strobe_t stb_o
);
  always_comb begin
    stb_o.f_rd = sel_i.flash_on & ~sel_i.oe_n & sel_i.we_n;
    // flash write inhibited by low OE, high WE, or an operation in progress
    stb_o.f_wr = sel_i.flash_on & ~sel_i.we_n & sel_i.oe_n & ~busy_i;
    stb_o.s_rd = sel_i.sram_on & ~sel_i.oe_n & sel_i.we_n;
    stb_o.s_wr = sel_i.sram_on & ~sel_i.we_n;
  end

  p_one_bank_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((stb_o.f_rd || stb_o.f_wr) && (stb_o.s_rd || stb_o.s_wr)));

  p_busy_no_fwr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !stb_o.f_wr);

  p_rd_wr_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((stb_o.f_rd || stb_o.s_rd) && (stb_o.f_wr || stb_o.s_wr)));
endmodule

// File: rtl/cbr_bus.sv
module cbr_bus
  import cbr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  strobe_t           stb_i,
  input  logic              idle_i,
  input  logic [DATA_W-1:0] s_rdata_i,
  input  logic [DATA_W-1:0] f_rdata_i,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              standby_o
);
  logic              oe_d;
  logic [DATA_W-1:0] dq_d;

  always_comb begin
    oe_d = stb_i.f_rd | stb_i.s_rd;
    if (stb_i.f_rd)      dq_d = f_rdata_i;
    else if (stb_i.s_rd) dq_d = s_rdata_i;
    else                 dq_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_oe_o   <= 1'b0;
      dq_o      <= '0;
      standby_o <= 1'b1;
    end else begin
      dq_oe_o   <= oe_d;
      dq_o      <= dq_d;
      standby_o <= idle_i;
    end
  end

  p_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> (!dq_oe_o && standby_o));

  p_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i.f_rd || stb_i.s_rd) |=> dq_oe_o);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));
endmodule

// File: rtl/combo_bank_router.sv
module combo_bank_router
  import cbr_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int SRAM_BYTES = 131072,
  parameter bit SHARED_PIN = 1'b0,
  localparam int SRAM_AW   = $clog2(SRAM_BYTES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flash_sel_ni,
  input  logic               sram_sel_ni,
  input  logic               out_en_ni,
  input  logic               wr_en_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               flash_busy_i,
  input  logic [DATA_W-1:0]  sram_rdata_i,
  input  logic [DATA_W-1:0]  flash_rdata_i,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic [ADDR_W-1:0]  flash_addr_o,
  output logic               sram_rd_o,
  output logic               sram_wr_o,
  output logic               flash_rd_o,
  output logic               flash_wr_o,
  output logic               dq_oe_o,
  output logic [DATA_W-1:0]  dq_o,
  output logic               standby_o
);
  sel_t    sel;
  strobe_t stb;
  logic    idle;

  cbr_select #(.SHARED_PIN(SHARED_PIN)) u_select (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flash_sel_ni (flash_sel_ni),
    .sram_sel_ni  (sram_sel_ni),
    .out_en_ni    (out_en_ni),
    .wr_en_ni     (wr_en_ni),
    .sel_o        (sel),
    .idle_o       (idle)
  );

  cbr_strobe u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .busy_i (flash_busy_i),
    .stb_o  (stb)
  );

  cbr_bus #(.DATA_W(DATA_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stb_i     (stb),
    .idle_i    (idle),
    .s_rdata_i (sram_rdata_i),
    .f_rdata_i (flash_rdata_i),
    .dq_oe_o   (dq_oe_o),
    .dq_o      (dq_o),
    .standby_o (standby_o)
  );

  // SRAM sits at the bottom of the space: only the low bits reach it
  assign sram_addr_o  = addr_i[SRAM_AW-1:0];
  assign flash_addr_o = addr_i;
  assign sram_rd_o    = stb.s_rd;
  assign sram_wr_o    = stb.s_wr;
  assign flash_rd_o   = stb.f_rd;
  assign flash_wr_o   = stb.f_wr;

  p_sram_busy_free_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_sel_ni && !sram_sel_ni && !SHARED_PIN && !wr_en_ni) |-> sram_wr_o);

  p_standby_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !dq_oe_o);
endmodule

// File: tb/combo_bank_router_tb.sv
module combo_bank_router_tb;
  localparam int AW = 19;
  localparam int DW = 8;
  localparam int SAW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsel_n = 1'b1, ssel_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] srd = '0, frd = '0;

  logic [SAW-1:0] a_s_addr, b_s_addr;
  logic [AW-1:0]  a_f_addr, b_f_addr;
  logic a_srd, a_swr, a_frd, a_fwr, a_oe, a_sb;
  logic b_srd, b_swr, b_frd, b_fwr, b_oe, b_sb;
  logic [DW-1:0] a_dq, b_dq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  combo_bank_router #(.SHARED_PIN(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .flash_sel_ni(fsel_n), .sram_sel_ni(ssel_n),
    .out_en_ni(oe_n), .wr_en_ni(we_n), .addr_i(addr), .flash_busy_i(busy),
    .sram_rdata_i(srd), .flash_rdata_i(frd), .sram_addr_o(a_s_addr),
    .flash_addr_o(a_f_addr), .sram_rd_o(a_srd), .sram_wr_o(a_swr),
    .flash_rd_o(a_frd), .flash_wr_o(a_fwr), .dq_oe_o(a_oe), .dq_o(a_dq),
    .standby_o(a_sb));

  combo_bank_router #(.SHARED_PIN(1'b1)) u_dut_sh (
    .clk_i(clk), .rst_ni(rst_n), .flash_sel_ni(fsel_n), .sram_sel_ni(ssel_n),
    .out_en_ni(oe_n), .wr_en_ni(we_n), .addr_i(addr), .flash_busy_i(busy),
    .sram_rdata_i(srd), .flash_rdata_i(frd), .sram_addr_o(b_s_addr),
    .flash_addr_o(b_f_addr), .sram_rd_o(b_srd), .sram_wr_o(b_swr),
    .flash_rd_o(b_frd), .flash_wr_o(b_fwr), .dq_oe_o(b_oe), .dq_o(b_dq),
    .standby_o(b_sb));

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected behaviour per instance; sh selects shared-pin mode
  task automatic step(input string req, input logic f, input logic s, input logic o,
                      input logic w, input logic b, input logic [AW-1:0] a,
                      input logic [DW-1:0] sd, input logic [DW-1:0] fd);
    bit e_frd[2], e_fwr[2], e_srd[2], e_swr[2], e_idle[2];
    logic [DW-1:0] e_dq[2];
    fsel_n = f; ssel_n = s; oe_n = o; we_n = w; busy = b; addr = a; srd = sd; frd = fd;
    for (int m = 0; m < 2; m++) begin
      bit sram_en_low, flash_live, sram_live;
      sram_en_low = (m == 1) ? !o : !s;
      flash_live  = !f;
      sram_live   = sram_en_low && f;
      e_frd[m]  = flash_live && !o && w;
      e_fwr[m]  = flash_live && !w && o && !b;
      e_srd[m]  = sram_live && !o && w;
      e_swr[m]  = sram_live && !w;
      e_idle[m] = f && !sram_en_low;
      e_dq[m]   = e_frd[m] ? fd : (e_srd[m] ? sd : '0);
    end
    #1;
    chk(req, "a.sram_rd", a_srd, e_srd[0]);
    chk(req, "a.sram_wr", a_swr, e_swr[0]);
    chk(req, "a.flash_rd", a_frd, e_frd[0]);
    chk(req, "a.flash_wr", a_fwr, e_fwr[0]);
    chk("R6", "a.sram_addr", a_s_addr, a[SAW-1:0]);
    chk("R6", "a.flash_addr", a_f_addr, a);
    chk(req, "b.sram_rd", b_srd, e_srd[1]);
    chk(req, "b.sram_wr", b_swr, e_swr[1]);
    chk(req, "b.flash_rd", b_frd, e_frd[1]);
    chk(req, "b.flash_wr", b_fwr, e_fwr[1]);
    chk("R6", "b.sram_addr", b_s_addr, a[SAW-1:0]);
    @(posedge clk);
    #1;
    chk(req, "a.dq_oe", a_oe, e_frd[0] || e_srd[0]);
    chk(req, "a.dq", a_dq, e_dq[0]);
    chk(req, "a.standby", a_sb, e_idle[0]);
    chk(req, "b.dq_oe", b_oe, e_frd[1] || e_srd[1]);
    chk(req, "b.dq", b_dq, e_dq[1]);
    chk(req, "b.standby", b_sb, e_idle[1]);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset a.dq_oe", a_oe, 0);
    chk("R9", "reset a.dq", a_dq, 0);
    chk("R9", "reset a.standby", a_sb, 1);
    chk("R9", "reset b.standby", b_sb, 1);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    // f s o w busy addr sd fd
    step("R2", 1, 1, 1, 1, 0, 19'h12345, 8'h11, 8'h22);
    step("R2", 1, 1, 0, 0, 0, 19'h00001, 8'h33, 8'h44);
    step("R3", 1, 0, 0, 1, 0, 19'h1ABCD, 8'h5A, 8'hA5);
    step("R3", 0, 1, 0, 1, 0, 19'h7FFFF, 8'h5A, 8'hC3);
    step("R4", 1, 0, 1, 0, 0, 19'h00010, 8'h00, 8'h00);
    step("R4", 1, 0, 0, 0, 0, 19'h00020, 8'h00, 8'h00);
    step("R1", 0, 0, 0, 1, 0, 19'h00030, 8'h77, 8'h88);
    step("R1", 0, 0, 1, 0, 0, 19'h00040, 8'h77, 8'h88);
    step("R5", 0, 1, 1, 0, 0, 19'h05555, 8'h00, 8'h00);
    step("R5", 0, 1, 0, 0, 0, 19'h05555, 8'h00, 8'h00);
    step("R5", 0, 1, 1, 1, 0, 19'h02AAA, 8'h00, 8'h00);
    step("R5", 0, 1, 1, 0, 1, 19'h05555, 8'h00, 8'h00);
    step("R7", 1, 0, 0, 1, 1, 19'h1FFFF, 8'h9C, 8'h01);
    step("R7", 1, 0, 1, 0, 1, 19'h0F0F0, 8'h9C, 8'h01);
    step("R6", 1, 0, 0, 1, 0, 19'h7FFFF, 8'hE1, 8'h02);
    step("R8", 0, 0, 0, 1, 0, 19'h00100, 8'h12, 8'h34);
    step("R8", 1, 0, 1, 1, 0, 19'h00200, 8'h12, 8'h34);
    step("R8", 1, 1, 0, 1, 0, 19'h00300, 8'h56, 8'h78);
    step("R10", 1, 0, 1, 1, 0, 19'h00400, 8'hFF, 8'hFF);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R3", r[0], r[1], r[2], r[3], r[4], AW'($urandom), DW'($urandom), DW'($urandom));
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule